// File: doc/BRIEF.md
# Multi-Channel DMA Request Router

This block sits between a bank of per-channel sample FIFOs and a small DMA engine. Each receive channel raises an almost-full flag and each transmit channel raises an almost-empty flag. The router picks, for every DMA request line, one channel of each direction and forwards that channel's flag as a request. A per-channel enable bit must also be set, or the request is masked. The router registers every request before it leaves the block.

The DMA engine answers with a one-cycle acknowledge pulse on a line. The router steers each pulse back to the channels that claim that line, using per-channel acknowledge-select fields. Receive and transmit directions have fully separate request lines, selects, acknowledge maps and acknowledge inputs, so the two directions never interact. All configuration arrives as static words from a neighbouring register block. The router holds no state of its own other than its output registers.

Top module: `dma_req_router`

## Requirements
- R1: While rst_ni is low, every request and acknowledge output is 0.
- R2: Receive line l carries the registered value of rx_af_i[s], where s is the 4-bit field rx_sel_i[4l+3:4l]. The output changes one clock after the inputs.
- R3: Transmit line l carries the registered value of tx_ae_i[s], where s is tx_sel_i[4l+3:4l]. The enable for transmit channel c is dma_en_i[16+c].
- R4: Each line's select field sits at bit offset 4 times the line index, so the fields are independent. Two lines may select the same channel.
- R5: A select value of NCH (10) or above routes nothing, and the line's request stays 0.
- R6: A request is forwarded only when the enable bit of the selected channel is set. The enable for receive channel c is dma_en_i[c]. A flag on a disabled channel never reaches any line.
- R7: A pulse on rx_ack_i[l] produces, one clock later, a pulse on rx_ack_o[c] for every channel c whose acknowledge field equals l.
- R8: An acknowledge field holding a value of NLINE (5) or above never matches a line, so that channel receives no acknowledge.
- R9: Transmit acknowledges are driven only from tx_ack_i through tx_ack_map_i. Receive acknowledge pulses never appear on tx_ack_o, and the reverse also holds.
- R10: The acknowledge field of channel c is map[4c+3:4c]. Channels 0 to 7 fill the lower 32-bit word, and channels 8 and 9 take bits 35:32 and 39:36.

Ports table (NCH = 10, NLINE = 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_en_i | input | 32 | Channel enables: receive at bits 0 and up, transmit at bits 16 and up |
| rx_sel_i | input | 4*NLINE | Receive channel select, one 4-bit field per line |
| tx_sel_i | input | 4*NLINE | Transmit channel select, one 4-bit field per line |
| rx_ack_map_i | input | 4*NCH | Receive acknowledge line select, one 4-bit field per channel |
| tx_ack_map_i | input | 4*NCH | Transmit acknowledge line select, one 4-bit field per channel |
| rx_af_i | input | NCH | Receive almost-full flags |
| tx_ae_i | input | NCH | Transmit almost-empty flags |
| rx_ack_i | input | NLINE | Receive acknowledge pulses from the DMA engine |
| tx_ack_i | input | NLINE | Transmit acknowledge pulses from the DMA engine |
| rx_req_o | output | NLINE | Receive DMA requests |
| tx_req_o | output | NLINE | Transmit DMA requests |
| rx_ack_o | output | NCH | Per-channel receive acknowledge strobes |
| tx_ack_o | output | NCH | Per-channel transmit acknowledge strobes |

## Verification
The bench builds the router with its default parameters: 10 channels and 5 lines per direction. With these values the 4-bit select fields can hold the out-of-range codes 10 to 15. The acknowledge fields can hold the codes 5 to 15, which name no line. Channels 8 and 9 land in the upper map word. The bench drives all of these codes in directed phases and during a random phase. A behavioural model predicts every output one clock ahead, and the bench compares against it on every cycle.

// File: rtl/dmarr_pkg.sv
package dmarr_pkg;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned EN_W      = 32;
  localparam int unsigned TX_EN_OFS = 16;
endpackage

// File: rtl/dmarr_line_sel.sv
module dmarr_line_sel
  import dmarr_pkg::*;
#(
  parameter int unsigned NCH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NCH-1:0]   flag_i,
  input  logic [NCH-1:0]   en_i,
  output logic             req_o
);
  logic req_d;

  // codes >= NCH match no channel and leave the line idle
  always_comb begin
    req_d = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (sel_i == SEL_W'(c)) req_d = flag_i[c] & en_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= req_d;
  end
endmodule

// File: rtl/dmarr_ack_steer.sv
module dmarr_ack_steer
  import dmarr_pkg::*;
#(
  parameter int unsigned NLINE = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] map_i,
  input  logic [NLINE-1:0] ack_i,
  output logic             ack_o
);
  logic ack_d;

  always_comb begin
    ack_d = 1'b0;
    for (int l = 0; l < NLINE; l++) begin
      if (map_i == SEL_W'(l)) ack_d = ack_i[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= 1'b0;
    else         ack_o <= ack_d;
  end
endmodule

// File: rtl/dmarr_dir.sv
module dmarr_dir
  import dmarr_pkg::*;
#(
  parameter int unsigned NCH   = 10,
  parameter int unsigned NLINE = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NCH-1:0]         en_i,
  input  logic [NCH-1:0]         flag_i,
  input  logic [NLINE*SEL_W-1:0] sel_i,
  input  logic [NCH*SEL_W-1:0]   map_i,
  input  logic [NLINE-1:0]       ack_i,
  output logic [NLINE-1:0]       req_o,
  output logic [NCH-1:0]         ack_o
);
  for (genvar l = 0; l < NLINE; l++) begin : g_line
    dmarr_line_sel #(.NCH(NCH)) u_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel_i[l*SEL_W +: SEL_W]),
      .flag_i (flag_i),
      .en_i   (en_i),
      .req_o  (req_o[l])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dmarr_ack_steer #(.NLINE(NLINE)) u_ack (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .map_i  (map_i[c*SEL_W +: SEL_W]),
      .ack_i  (ack_i),
      .ack_o  (ack_o[c])
    );
  end
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmarr_pkg::*;
#(
  parameter int unsigned NCH   = 10,
  parameter int unsigned NLINE = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [EN_W-1:0]        dma_en_i,
  input  logic [NLINE*SEL_W-1:0] rx_sel_i,
  input  logic [NLINE*SEL_W-1:0] tx_sel_i,
  input  logic [NCH*SEL_W-1:0]   rx_ack_map_i,
  input  logic [NCH*SEL_W-1:0]   tx_ack_map_i,
  input  logic [NCH-1:0]         rx_af_i,
  input  logic [NCH-1:0]         tx_ae_i,
  input  logic [NLINE-1:0]       rx_ack_i,
  input  logic [NLINE-1:0]       tx_ack_i,
  output logic [NLINE-1:0]       rx_req_o,
  output logic [NLINE-1:0]       tx_req_o,
  output logic [NCH-1:0]         rx_ack_o,
  output logic [NCH-1:0]         tx_ack_o
);
  localparam int unsigned RX_GAP = TX_EN_OFS - NCH;
  localparam int unsigned TX_GAP = EN_W - TX_EN_OFS - NCH;

  initial begin
    if (NCH >= TX_EN_OFS || NCH > (1 << SEL_W) || NLINE > (1 << SEL_W))
      $error("dma_req_router: parameters exceed field widths");
  end

  logic [NCH-1:0] rx_en, tx_en;
  assign rx_en = dma_en_i[0 +: NCH];
  assign tx_en = dma_en_i[TX_EN_OFS +: NCH];

  logic unused_en;
  assign unused_en = ^{dma_en_i[NCH +: RX_GAP], dma_en_i[TX_EN_OFS+NCH +: TX_GAP]};

  dmarr_dir #(.NCH(NCH), .NLINE(NLINE)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en),
    .flag_i (rx_af_i),
    .sel_i  (rx_sel_i),
    .map_i  (rx_ack_map_i),
    .ack_i  (rx_ack_i),
    .req_o  (rx_req_o),
    .ack_o  (rx_ack_o)
  );

  dmarr_dir #(.NCH(NCH), .NLINE(NLINE)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tx_en),
    .flag_i (tx_ae_i),
    .sel_i  (tx_sel_i),
    .map_i  (tx_ack_map_i),
    .ack_i  (tx_ack_i),
    .req_o  (tx_req_o),
    .ack_o  (tx_ack_o)
  );
endmodule

// File: rtl/dma_req_router_chk.sv
module dma_req_router_chk
  import dmarr_pkg::*;
#(
  parameter int unsigned NCH   = 10,
  parameter int unsigned NLINE = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [EN_W-1:0]        dma_en_i,
  input logic [NCH*SEL_W-1:0]   rx_ack_map_i,
  input logic [NLINE-1:0]       rx_ack_i,
  input logic [NLINE-1:0]       tx_ack_i,
  input logic [NLINE-1:0]       rx_req_o,
  input logic [NLINE-1:0]       tx_req_o,
  input logic [NCH-1:0]         rx_ack_o,
  input logic [NCH-1:0]         tx_ack_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (rx_req_o == '0 && tx_req_o == '0 && rx_ack_o == '0 && tx_ack_o == '0)); // R1

  AST_RX_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_req_o) |-> $past(|dma_en_i[0 +: NCH])); // R6

  AST_TX_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_req_o) |-> $past(|dma_en_i[TX_EN_OFS +: NCH])); // R3

  AST_RX_ACK_FROM_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_ack_o) |-> $past(|rx_ack_i)); // R7

  AST_TX_ACK_OWN_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_ack_o) |-> $past(|tx_ack_i)); // R9

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_BAD_ACK_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rx_ack_map_i[c*SEL_W +: SEL_W] >= SEL_W'(NLINE)) |-> !rx_ack_o[c]); // R8
  end
endmodule

bind dma_req_router dma_req_router_chk #(.NCH(NCH), .NLINE(NLINE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dma_en_i     (dma_en_i),
  .rx_ack_map_i (rx_ack_map_i),
  .rx_ack_i     (rx_ack_i),
  .tx_ack_i     (tx_ack_i),
  .rx_req_o     (rx_req_o),
  .tx_req_o     (tx_req_o),
  .rx_ack_o     (rx_ack_o),
  .tx_ack_o     (tx_ack_o)
);

// File: tb/tb_dma_req_router.sv
`timescale 1ns/1ps
module tb_dma_req_router;
  localparam int NCH = 10;
  localparam int NLINE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] dma_en = '0;
  logic [NLINE*4-1:0] rx_sel = '0, tx_sel = '0;
  logic [NCH*4-1:0] rx_map = '1, tx_map = '1;
  logic [NCH-1:0] rx_af = '0, tx_ae = '0;
  logic [NLINE-1:0] rx_ack = '0, tx_ack = '0;
  logic [NLINE-1:0] rx_req, tx_req;
  logic [NCH-1:0] rx_ack_o, tx_ack_o;

  always #2 clk = ~clk;

  dma_req_router #(.NCH(NCH), .NLINE(NLINE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dma_en_i(dma_en),
    .rx_sel_i(rx_sel), .tx_sel_i(tx_sel),
    .rx_ack_map_i(rx_map), .tx_ack_map_i(tx_map),
    .rx_af_i(rx_af), .tx_ae_i(tx_ae),
    .rx_ack_i(rx_ack), .tx_ack_i(tx_ack),
    .rx_req_o(rx_req), .tx_req_o(tx_req),
    .rx_ack_o(rx_ack_o), .tx_ack_o(tx_ack_o)
  );

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit done = 0;
  logic [NLINE-1:0] e_rx_req = '0, e_tx_req = '0;
  logic [NCH-1:0] e_rx_ack = '0, e_tx_ack = '0;

  // behavioural reference: one register stage per output
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_rx_req = '0; e_tx_req = '0; e_rx_ack = '0; e_tx_ack = '0;
    end else begin
      for (int l = 0; l < NLINE; l++) begin
        int s, t;
        s = int'(rx_sel[l*4 +: 4]);
        t = int'(tx_sel[l*4 +: 4]);
        e_rx_req[l] = (s < NCH) ? (rx_af[s] && dma_en[s]) : 1'b0;
        e_tx_req[l] = (t < NCH) ? (tx_ae[t] && dma_en[16+t]) : 1'b0;
      end
      for (int c = 0; c < NCH; c++) begin
        int a, b;
        a = int'(rx_map[c*4 +: 4]);
        b = int'(tx_map[c*4 +: 4]);
        e_rx_ack[c] = (a < NLINE) ? rx_ack[a] : 1'b0;
        e_tx_ack[c] = (b < NLINE) ? tx_ack[b] : 1'b0;
      end
    end
  end

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk({tag, " rx_req"}, 16'(rx_req), 16'(e_rx_req));
    chk({tag, " tx_req"}, 16'(tx_req), 16'(e_tx_req));
    chk({tag, " rx_ack"}, 16'(rx_ack_o), 16'(e_rx_ack));
    chk({tag, " tx_ack"}, 16'(tx_ack_o), 16'(e_tx_ack));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs low even with live inputs
    tag = "R1";
    dma_en = '1; rx_af = '1; tx_ae = '1; rx_map = '0; rx_ack = '1;
    cyc(3);
    chk("R1 reset rx_req", 16'(rx_req), 16'h0);
    chk("R1 reset rx_ack", 16'(rx_ack_o), 16'h0);
    rx_ack = '0; rx_af = '0; tx_ae = '0; dma_en = '0; rx_map = '1;
    @(negedge clk); rst_n = 1'b1;
    cyc(2);

    // R2, R4: receive routing, line l selects channel 2l+1
    tag = "R2";
    dma_en = 32'h0000_03FF;
    for (int l = 0; l < NLINE; l++) rx_sel[l*4 +: 4] = 4'(2*l+1);
    for (int c = 0; c < NCH; c++) begin
      rx_af = NCH'(1) << c; cyc(2);
    end
    tag = "R4";
    rx_sel = {4'd9, 4'd9, 4'd0, 4'd0, 4'd9};
    rx_af = 10'b10_0000_0001; cyc(2);
    chk("R4 shared select", 16'(rx_req), 16'h1F);

    // R6: disabled channels are masked
    tag = "R6";
    dma_en = 32'h0000_0001; cyc(2);
    chk("R6 masked ch9", 16'(rx_req), 16'h06);
    dma_en = 32'h0001_0200; rx_af = '1; cyc(2);
    chk("R6 tx enables do not gate rx", 16'(rx_req), 16'h19);

    // R3: transmit routing uses enable bits 16 and up
    tag = "R3";
    rx_af = '0;
    tx_sel = {4'd4, 4'd3, 4'd2, 4'd1, 4'd0};
    tx_ae = '1; dma_en = 32'h0000_03FF; cyc(2);
    chk("R3 low enables ignored for tx", 16'(tx_req), 16'h0);
    dma_en = 32'h0015_0000; cyc(2);
    chk("R3 tx enable 16+c", 16'(tx_req), 16'h15);

    // R5: out-of-range select codes
    tag = "R5";
    dma_en = '1; rx_af = '1;
    rx_sel = {4'd15, 4'd12, 4'd11, 4'd10, 4'd9};
    tx_sel = {4'd10, 4'd13, 4'd14, 4'd15, 4'd0};
    cyc(2);
    chk("R5 invalid rx select", 16'(rx_req), 16'h01);
    chk("R5 invalid tx select", 16'(tx_req), 16'h01);
    tx_ae = '0; rx_af = '0;

    // R7, R10: ack steering incl. channels 8,9 in upper word
    tag = "R7";
    for (int c = 0; c < NCH; c++) rx_map[c*4 +: 4] = 4'(c % NLINE);
    for (int l = 0; l < NLINE; l++) begin
      rx_ack = NLINE'(1) << l; @(negedge clk); rx_ack = '0; @(negedge clk);
    end
    tag = "R10";
    rx_map = '1; rx_map[39:36] = 4'd2; rx_map[35:32] = 4'd4;
    rx_ack = 5'b10100; @(negedge clk); rx_ack = '0;
    chk("R10 ch8/ch9 fields", 16'(rx_ack_o), 16'h300);
    @(negedge clk);

    // R8: field values naming no line
    tag = "R8";
    for (int c = 0; c < NCH; c++) rx_map[c*4 +: 4] = 4'(5 + c);
    rx_ack = '1; @(negedge clk); rx_ack = '0;
    chk("R8 invalid ack field", 16'(rx_ack_o), 16'h0);
    @(negedge clk);

    // R9: direction isolation
    tag = "R9";
    rx_map = '0; tx_map = '0;
    rx_ack = 5'b00001; @(negedge clk); rx_ack = '0;
    chk("R9 rx ack not on tx", 16'(tx_ack_o), 16'h0);
    tx_ack = 5'b00001; @(negedge clk); tx_ack = '0;
    chk("R9 tx ack not on rx", 16'(rx_ack_o), 16'h0);
    @(negedge clk);

    // random mix, all requirements against the model
    tag = "R2 random";
    for (int i = 0; i < 600; i++) begin
      dma_en = $urandom; rx_sel = 20'($urandom); tx_sel = 20'($urandom);
      rx_map = {8'($urandom), 32'($urandom)}; tx_map = {8'($urandom), 32'($urandom)};
      rx_af = 10'($urandom); tx_ae = 10'($urandom);
      rx_ack = 5'($urandom); tx_ack = 5'($urandom);
      @(negedge clk);
    end
    rx_ack = '0; tx_ack = '0;
    cyc(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule